// File: doc/BRIEF.md
# Phase-Staggered Multi-Channel PWM Generator

This block produces nine pulse-width-modulated output levels from one shared 32-step period counter. The counter advances only on a tick-enable strobe, nominally at 1 kHz, so one period lasts 32 ticks. Each output has its own 8-bit setting. The setting either selects a duty of 0 to 31 thirty-seconds, or forces the output to a static high level.

Each output starts its high time at a fixed phase offset within the period. Outputs are offset in pairs by one eighth of the period. This spreads the switching edges over the whole period and lowers the peak supply current. Settings are written over a plain parallel port that carries a port index and a data byte. A new setting takes effect only when that output's own period starts, so no runt pulses appear. A synchronous clear strobe, gated by an enable input, returns the shared counter to zero so that several blocks can be aligned.

Top module: `staggered_pwm_bank`

## Requirements
- R1: The shared counter has five bits and counts 0 to 31, then wraps to 0. It advances by one on each cycle with `tick_en` high and holds its value on every other cycle.
- R2: For an active duty value N between 1 and 31, output i is high for the N consecutive counter values that start at its offset, wrapping modulo 32. It is low for the rest of the period.
- R3: An active setting whose low five bits are zero, and whose upper nibble is not 0111, holds the output static low.
- R4: An active setting whose bits [7:4] equal 4'b0111 holds the output static high, whatever bits [3:0] hold. Any other setting uses bits [4:0] as the duty, and bits [7:5] are ignored.
- R5: Output i has a phase offset of 4*floor(i/2) counter values. Ports 0 and 1 use offset 0, ports 2 and 3 use offset 4, and so on up to port 8, which uses offset 16.
- R6: A written setting is held in a shadow register. It becomes active only on the clock edge where the counter moves to that port's offset value, whether by a tick or by a clear. Until then, the output follows the previous setting.
- R7: When `clr_en` and `cnt_clr` are both high, the counter becomes 0 on the next edge, and this takes priority over a tick. When `clr_en` is low, `cnt_clr` has no effect.
- R8: After reset, all shadow and active settings are zero, the counter is zero, and all nine outputs are low.
- R9: A write with `wr_port` set to 9 or more changes no setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | PWM tick strobe; advances the shared counter |
| clr_en | input | 1 | Configuration bit that enables `cnt_clr` |
| cnt_clr | input | 1 | Synchronous clear strobe for the shared counter |
| wr_en | input | 1 | Setting write strobe |
| wr_port | input | 4 | Index of the port to write |
| wr_data | input | 8 | New setting value |
| pwm_out | output | 9 | Output levels, bit i for port i |

## Verification
The bench builds the block with its default parameters: nine ports, a 5-bit counter, a phase step of 4 and a pair grouping of 2. With these values, port 8 lands alone at offset 16, and the 4-bit index reaches the unused values 9 to 15. Ticks arrive both on every cycle and on every third cycle, so counter holds are exercised alongside advances. The clear strobe is applied at the same time as a tick, so setting loads triggered by a clear are exercised as well as those triggered by a tick.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

   // Phase offset of a port: ports are grouped, and each group moves by one step.
   function automatic int unsigned port_offset(input int unsigned idx,
                                               input int unsigned step,
                                               input int unsigned group,
                                               input int unsigned period);
      return (step * (idx / group)) % period;
   endfunction

endpackage

// File: rtl/spwm_counter.sv
module spwm_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             clr_req,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_next,
   output logic             adv
);

   always_comb begin
      if (clr_req)      cnt_next = '0;
      else if (tick_en) cnt_next = cnt_q + 1'b1;
      else              cnt_next = cnt_q;
   end

   assign adv = clr_req | tick_en;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_next;
   end

   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !clr_req) |=> (cnt_q == $past(cnt_q) + 1'b1));
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !clr_req) |=> $stable(cnt_q));
   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> (cnt_q == '0));

endmodule

// File: rtl/spwm_channel.sv
module spwm_channel #(
   parameter int          CNT_W     = 5,
   parameter int          SET_W     = 8,
   parameter int unsigned OFFSET    = 0,
   parameter logic [3:0]  HIGH_CODE = 4'b0111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [SET_W-1:0] wr_data,
   input  logic             adv,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic [CNT_W-1:0] cnt_next,
   output logic             level
);

   localparam logic [CNT_W-1:0] OFF_C = OFFSET[CNT_W-1:0];

   logic [SET_W-1:0] shadow_q;
   logic [SET_W-1:0] active_q;
   logic [CNT_W-1:0] phase;
   logic [CNT_W-1:0] duty;
   logic             force_hi;
   logic             load;

   assign load = adv && (cnt_next == OFF_C);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         active_q <= '0;
      end else begin
         if (wr_hit) shadow_q <= wr_data;
         if (load)   active_q <= shadow_q;
      end
   end

   generate
      if (OFFSET == 0) begin : g_zero_phase
         assign phase = cnt_q;
      end else begin : g_shift_phase
         assign phase = cnt_q - OFF_C;
      end
   endgenerate

   assign duty     = active_q[CNT_W-1:0];
   assign force_hi = (active_q[SET_W-1 -: 4] == HIGH_CODE);
   assign level    = force_hi | (phase < duty);

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(active_q));
   a_r9_shadow_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(shadow_q));
   a_r3_static_low: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q == '0) |-> !level);
   a_r4_static_high: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q[SET_W-1 -: 4] == HIGH_CODE) |-> level);
   a_r2_rise_at_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == OFF_C && duty != '0) |-> level);

endmodule

// File: rtl/staggered_pwm_bank.sv
module staggered_pwm_bank #(
   parameter int NUM_PORTS  = 9,
   parameter int CNT_W      = 5,
   parameter int SET_W      = 8,
   parameter int IDX_W      = 4,
   parameter int PHASE_STEP = 4,
   parameter int GROUP      = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 clr_en,
   input  logic                 cnt_clr,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_port,
   input  logic [SET_W-1:0]     wr_data,
   output logic [NUM_PORTS-1:0] pwm_out
);

   localparam int PERIOD = 1 << CNT_W;

   generate
      if (NUM_PORTS < 1 || NUM_PORTS > (1 << IDX_W)) begin : g_bad_ports
         $error("port count does not fit the index width");
      end
      if (SET_W < CNT_W || SET_W < 4) begin : g_bad_set
         $error("setting too narrow for duty and force code");
      end
      if (GROUP < 1 || PHASE_STEP < 1 || PHASE_STEP >= PERIOD) begin : g_bad_phase
         $error("phase grouping parameters out of range");
      end
   endgenerate

   logic [CNT_W-1:0]     cnt_q;
   logic [CNT_W-1:0]     cnt_next;
   logic                 adv;
   logic                 clr_req;
   logic [NUM_PORTS-1:0] wr_hit;

   assign clr_req = clr_en & cnt_clr;

   spwm_counter #(.CNT_W(CNT_W)) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .clr_req  (clr_req),
      .cnt_q    (cnt_q),
      .cnt_next (cnt_next),
      .adv      (adv)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PORTS; gi++) begin : g_port
         assign wr_hit[gi] = wr_en && (wr_port == gi[IDX_W-1:0]);

         spwm_channel #(
            .CNT_W  (CNT_W),
            .SET_W  (SET_W),
            .OFFSET (spwm_pkg::port_offset(gi, PHASE_STEP, GROUP, PERIOD))
         ) i_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_hit[gi]),
            .wr_data  (wr_data),
            .adv      (adv),
            .cnt_q    (cnt_q),
            .cnt_next (cnt_next),
            .level    (pwm_out[gi])
         );
      end
   endgenerate

   a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_hit));
   a_r9_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_port >= NUM_PORTS) |-> (wr_hit == '0));
   a_r8_reset_low: assert property (@(posedge clk)
      !rst_n |=> (pwm_out == '0));

endmodule

// File: tb/test_staggered_pwm_bank.sv
module test_staggered_pwm_bank;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       tick_en = 0;
   logic       clr_en = 0;
   logic       cnt_clr = 0;
   logic       wr_en = 0;
   logic [3:0] wr_port = '0;
   logic [7:0] wr_data = '0;
   logic [8:0] pwm_out;

   always #10 clk = ~clk;   // 50 MHz

   staggered_pwm_bank i_staggered_pwm_bank (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr_en(clr_en),
      .cnt_clr(cnt_clr), .wr_en(wr_en), .wr_port(wr_port),
      .wr_data(wr_data), .pwm_out(pwm_out)
   );

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done     = 0;
   string tag      = "R8";

   // Reference model
   int m_cnt = 0;
   int m_shadow[9];
   int m_active[9];

   function automatic int offs(int i);
      return 4 * (i / 2);
   endfunction

   function automatic logic [8:0] model_out();
      logic [8:0] r;
      for (int i = 0; i < 9; i++) begin
         int ph;
         ph = (m_cnt - offs(i) + 32) % 32;
         if (((m_active[i] >> 4) & 15) == 7) r[i] = 1'b1;
         else                                r[i] = (ph < (m_active[i] & 31));
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0;
         for (int i = 0; i < 9; i++) begin m_shadow[i] = 0; m_active[i] = 0; end
      end else begin
         int  nc;
         bit  moved;
         moved = 0;
         nc = m_cnt;
         if (clr_en && cnt_clr) begin nc = 0; moved = 1; end
         else if (tick_en)      begin nc = (m_cnt + 1) % 32; moved = 1; end
         for (int i = 0; i < 9; i++)
            if (moved && nc == offs(i)) m_active[i] = m_shadow[i];
         if (wr_en && wr_port < 9) m_shadow[wr_port] = wr_data;
         m_cnt = nc;
      end
   end

   // Per-cycle comparison
   always @(negedge clk) begin
      if (!done) begin
         logic [8:0] e;
         e = model_out();
         n_checks++;
         if (pwm_out !== e) begin
            n_fails++;
            $display("FAIL %s cycle compare: actual %b expected %b", tag, pwm_out, e);
         end
      end
   end

   task automatic check_out(input logic [8:0] exp, input string rq);
      n_checks++;
      if (pwm_out !== exp) begin
         n_fails++;
         $display("FAIL %s direct check: actual %b expected %b", rq, pwm_out, exp);
      end
   endtask

   task automatic write_set(input int p, input int v);
      @(negedge clk);
      wr_en = 1; wr_port = p[3:0]; wr_data = v[7:0];
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic run(input int n, input int every);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         tick_en = ((k % every) == 0);
      end
      @(negedge clk);
      tick_en = 0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      // R8: reset with ticks present
      tick_en = 1;
      repeat (5) @(negedge clk);
      check_out(9'h000, "R8");
      rst_n = 1;
      tick_en = 0;
      @(negedge clk);
      check_out(9'h000, "R8");

      // R3: all settings zero stay low
      tag = "R3";
      run(40, 1);
      check_out(9'h000, "R3");

      // R5 / R2: equal duty shows pairwise stagger
      tag = "R5";
      for (int i = 0; i < 9; i++) write_set(i, 4);
      run(80, 1);

      // R2: varied duties, slow ticks
      tag = "R2";
      for (int i = 0; i < 8; i++) write_set(i, 3 * i + 1);
      write_set(8, 31);
      run(100, 3);

      // R4: force code and ignored upper bits
      tag = "R4";
      write_set(0, 8'h7A);
      write_set(1, 8'h65);
      write_set(8, 8'h70);
      run(70, 1);

      // R6: mid-period change takes effect at own period start
      tag = "R6";
      run(10, 1);
      write_set(3, 20);
      write_set(6, 0);
      run(45, 1);

      // R7: clear together with a tick, then clear while disabled
      tag = "R7";
      run(13, 1);
      @(negedge clk);
      clr_en = 1; cnt_clr = 1; tick_en = 1;
      @(negedge clk);
      cnt_clr = 0; tick_en = 0;
      write_set(2, 9);
      run(9, 1);
      @(negedge clk);
      cnt_clr = 1; tick_en = 0;
      @(negedge clk);
      cnt_clr = 0;
      run(20, 1);
      @(negedge clk);
      clr_en = 0; cnt_clr = 1; tick_en = 1;
      @(negedge clk);
      cnt_clr = 0; tick_en = 0;
      run(40, 1);

      // R9: writes to out-of-range indices change nothing
      tag = "R9";
      for (int p = 9; p < 16; p++) write_set(p, 8'h70);
      run(40, 1);

      // R1: outputs hold while no ticks arrive, then counting resumes
      tag = "R1";
      begin
         logic [8:0] held;
         run(7, 1);
         @(negedge clk);
         held = pwm_out;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check_out(held, "R1");
         end
      end
      run(70, 1);

      finish_up();
   end

endmodule